// File: doc/BRIEF.md
# Two-Key Register Write Protection Gate

This block sits between a peripheral's register bus and its register file and decides, cycle by cycle, whether a register write may land. Register writes are discarded while the gate is sealed. To open it, software writes a first 32-bit key value to one key slot and then a second, different 32-bit key value to another key slot. Any other value written to either key slot, zero included, seals the gate again. Reads always pass.

The gate holds no copy of the keys it receives. Each key write is compared on the fly against a parameter value, and only a small sequence state is kept. The register file uses `reg_wr_en` as its write strobe and `rd_grant` as its read strobe, and keeps using the bus address and data directly. Writes to the two key slots are taken by the gate and never reach the register file.

Top module: `reg_unlock_gate`

## Requirements
- R1: After a synchronous reset the gate is sealed: `locked` is 1 and `armed` is 0.
- R2: While `locked` is 1, a write to any address other than the two key slots leaves `reg_wr_en` at 0 in that cycle.
- R3: Writing 0x83E70B13 to the first key slot (byte offset 0x6C), then 0x95A4F1E0 to the second key slot (byte offset 0x70), opens the gate. `armed` goes to 1 on the clock edge that takes the first key. `locked` goes to 0 on the clock edge that takes the second key. After that, writes to other addresses assert `reg_wr_en` in the same cycle.
- R4: Order matters. A correct second key written while the gate is sealed and not armed does not open it, and a first key written afterwards only arms the gate.
- R5: Writing any value other than the expected key to either key slot, zero included, seals the gate on the next clock edge, with `locked` at 1 and `armed` at 0.
- R6: A key write counts as correct only when all four byte strobes in `wr_strb` are 1. A partial-strobe key write is treated as a wrong value.
- R7: `rd_grant` equals `rd_en` in the same cycle, whatever the lock state.
- R8: Writes to the two key slots never assert `reg_wr_en`, even while the gate is open.
- R9: While the gate is open, a correct first key write re-arms it. `locked` returns to 1 and `armed` to 1, so the second key must be written again. A correct second key written while the gate is open keeps it open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, one cycle per write |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte strobes of the write |
| rd_en | input | 1 | Read request |
| reg_wr_en | output | 1 | Qualified write strobe to the register file |
| rd_grant | output | 1 | Read strobe to the register file |
| locked | output | 1 | 1 while protected writes are being discarded |
| armed | output | 1 | 1 once the first key has been taken and the second is awaited |

## Verification
The embedded properties take it for granted that each write request lasts one cycle, and that address, data and strobes are free of unknown values whenever `wr_en` is high. They also expect the sequence state to move only on clock edges that carry a key write. The bench holds to this by changing every input on the falling clock edge, keeping a request for exactly one cycle, and leaving all bus inputs at defined values between requests. It samples `reg_wr_en` and `rd_grant` just after the inputs settle and before the next rising edge, and reads `locked` and `armed` just after the rising edge that takes a key write.

// File: rtl/ulg_pkg.sv
package ulg_pkg;

    // Sequence position of the gate.
    typedef enum logic [1:0] {
        ST_SEALED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2
    } gate_state_e;

    // One decoded bus write as seen by the key sequencer.
    typedef struct packed {
        logic to_first;     // write targets the first key slot
        logic to_second;    // write targets the second key slot
        logic first_good;   // full-word write carrying the first key
        logic second_good;  // full-word write carrying the second key
    } key_evt_t;

    localparam key_evt_t KEY_EVT_NONE = '{default: 1'b0};

    // Next sequence position for a given key event.
    function automatic gate_state_e step_gate(input gate_state_e cur, input key_evt_t ev);
        gate_state_e nxt;
        nxt = cur;
        if (ev.to_first) begin
            nxt = ev.first_good ? ST_HALF : ST_SEALED;
        end else if (ev.to_second) begin
            if (!ev.second_good) begin
                nxt = ST_SEALED;
            end else if (cur == ST_HALF || cur == ST_OPEN) begin
                nxt = ST_OPEN;
            end else begin
                nxt = ST_SEALED;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ulg_key_decode.sv
module ulg_key_decode
    import ulg_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SLOT0_OFS = 8'h6C,
    parameter logic [ADDR_W-1:0] SLOT1_OFS = 8'h70,
    parameter logic [DATA_W-1:0] SLOT0_KEY = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] SLOT1_KEY = 32'h95A4_F1E0
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_strb,
    output key_evt_t            evt,
    output logic                is_key
);
    localparam int STRB_W = DATA_W / 8;

    logic hit0, hit1, full_word;

    always_comb begin
        hit0      = (wr_addr == SLOT0_OFS);
        hit1      = (wr_addr == SLOT1_OFS);
        full_word = (wr_strb == {STRB_W{1'b1}});
        is_key    = hit0 | hit1;
        evt       = KEY_EVT_NONE;
        if (wr_en) begin
            evt.to_first    = hit0;
            evt.to_second   = hit1;
            evt.first_good  = hit0 & full_word & (wr_data == SLOT0_KEY);
            evt.second_good = hit1 & full_word & (wr_data == SLOT1_KEY);
        end
    end

endmodule

// File: rtl/ulg_seq.sv
module ulg_seq
    import ulg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  key_evt_t evt,
    output logic     locked,
    output logic     armed
);
    gate_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEALED;
        end else begin
            state_q <= step_gate(state_q, evt);
        end
    end

    always_comb begin
        locked = (state_q != ST_OPEN);
        armed  = (state_q == ST_HALF);
    end

    // R3: opening is always caused by a correct second key in the cycle before
    assert_open_by_second_key_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(!locked) |-> $past(evt.to_second && evt.second_good));

    // R4: the gate only opens out of the armed position
    assert_open_from_armed_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_OPEN) |-> $past(state_q) == ST_HALF);

    // R5: a wrong value at either slot seals the gate
    assert_bad_key_seals_R5: assert property (@(posedge clk) disable iff (rst)
        ((evt.to_first && !evt.first_good) || (evt.to_second && !evt.second_good))
        |=> (locked && !armed));

    // R9: a correct first key always leaves the gate armed and locked
    assert_first_key_arms_R9: assert property (@(posedge clk) disable iff (rst)
        (evt.to_first && evt.first_good) |=> (armed && locked));

endmodule

// File: rtl/ulg_wr_qual.sv
module ulg_wr_qual (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic is_key,
    input  logic locked,
    input  logic rd_en,
    output logic reg_wr_en,
    output logic rd_grant
);
    always_comb begin
        reg_wr_en = wr_en & ~is_key & ~locked;
        rd_grant  = rd_en;
    end

    // R2: nothing reaches the register file while sealed or armed
    assert_sealed_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        locked |-> !reg_wr_en);

    // R8: key slot writes are consumed by the gate
    assert_key_not_forwarded_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_key) |-> !reg_wr_en);

    // R7: reads are never withheld
    assert_read_free_R7: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_grant);

endmodule

// File: rtl/reg_unlock_gate.sv
module reg_unlock_gate
    import ulg_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SLOT0_OFS = 8'h6C,
    parameter logic [ADDR_W-1:0] SLOT1_OFS = 8'h70,
    parameter logic [DATA_W-1:0] SLOT0_KEY = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] SLOT1_KEY = 32'h95A4_F1E0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_strb,
    input  logic                rd_en,
    output logic                reg_wr_en,
    output logic                rd_grant,
    output logic                locked,
    output logic                armed
);
    key_evt_t evt;
    logic     is_key;

    ulg_key_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SLOT0_OFS(SLOT0_OFS),
        .SLOT1_OFS(SLOT1_OFS),
        .SLOT0_KEY(SLOT0_KEY),
        .SLOT1_KEY(SLOT1_KEY)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .wr_strb(wr_strb),
        .evt    (evt),
        .is_key (is_key)
    );

    ulg_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .locked(locked),
        .armed (armed)
    );

    ulg_wr_qual u_qual (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .is_key   (is_key),
        .locked   (locked),
        .rd_en    (rd_en),
        .reg_wr_en(reg_wr_en),
        .rd_grant (rd_grant)
    );

endmodule

// File: tb/reg_unlock_gate_bench.sv
module reg_unlock_gate_bench;

    localparam logic [7:0]  OFS0 = 8'h6C;
    localparam logic [7:0]  OFS1 = 8'h70;
    localparam logic [31:0] K0   = 32'h83E7_0B13;
    localparam logic [31:0] K1   = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = '0;
    logic        rd_en = 1'b0;
    logic        reg_wr_en, rd_grant, locked, armed;

    int n_checks = 0;
    int n_fail   = 0;
    logic seen_wr;
    logic seen_rd;

    always #2.5 clk = ~clk;

    reg_unlock_gate u_reg_unlock_gate (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .rd_en(rd_en),
        .reg_wr_en(reg_wr_en), .rd_grant(rd_grant),
        .locked(locked), .armed(armed)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One-cycle write; reg_wr_en sampled before the edge, state after it.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
        #1 seen_wr = reg_wr_en;
        @(posedge clk);
        #1 wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_strb = '0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        rd_en = 1'b1; wr_addr = a;
        #1 seen_rd = rd_grant;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic open_gate();
        bus_write(OFS0, K0, 4'hF);
        bus_write(OFS1, K1, 4'hF);
    endtask

    task automatic t_reset();
        check("R1 locked after reset", locked, 1'b1);
        check("R1 not armed after reset", armed, 1'b0);
    endtask

    task automatic t_sealed_writes();
        bus_write(8'h00, 32'h12, 4'hF);
        check("R2 write blocked while sealed", seen_wr, 1'b0);
        bus_write(8'h60, 32'hA5A5_A5A5, 4'hF);
        check("R2 scratch write blocked", seen_wr, 1'b0);
        bus_read(8'h00);
        check("R7 read granted while sealed", seen_rd, 1'b1);
    endtask

    task automatic t_unlock();
        bus_write(OFS0, K0, 4'hF);
        check("R3 armed after first key", armed, 1'b1);
        check("R3 still locked after first key", locked, 1'b1);
        check("R8 first key not forwarded", seen_wr, 1'b0);
        bus_write(OFS1, K1, 4'hF);
        check("R3 open after second key", locked, 1'b0);
        check("R8 second key not forwarded", seen_wr, 1'b0);
        bus_write(8'h04, 32'h59, 4'hF);
        check("R3 protected write passes when open", seen_wr, 1'b1);
        bus_read(8'h04);
        check("R7 read granted while open", seen_rd, 1'b1);
        bus_write(OFS1, K1, 4'hF);
        check("R9 repeated second key keeps open", locked, 1'b0);
        check("R8 key write blocked while open", seen_wr, 1'b0);
    endtask

    task automatic t_zero_relock();
        bus_write(OFS0, 32'h0, 4'hF);
        check("R5 zero at first slot seals", locked, 1'b1);
        bus_write(8'h48, 32'h8, 4'hF);
        check("R2 write blocked after relock", seen_wr, 1'b0);
        open_gate();
        bus_write(OFS1, 32'h0, 4'hF);
        check("R5 zero at second slot seals", locked, 1'b1);
        check("R5 zero at second slot disarms", armed, 1'b0);
    endtask

    task automatic t_order();
        bus_write(OFS1, K1, 4'hF);
        check("R4 second key alone stays locked", locked, 1'b1);
        check("R4 second key alone does not arm", armed, 1'b0);
        bus_write(OFS0, K0, 4'hF);
        check("R4 first key after second only arms", armed, 1'b1);
        check("R4 still locked", locked, 1'b1);
        bus_write(OFS1, K1, 4'hF);
        check("R3 proper order then opens", locked, 1'b0);
    endtask

    task automatic t_bad_values();
        bus_write(OFS0, K0, 4'hF);
        bus_write(OFS1, K0, 4'hF);
        check("R5 wrong second value seals", locked, 1'b1);
        check("R5 wrong second value disarms", armed, 1'b0);
        bus_write(OFS0, K1, 4'hF);
        check("R5 wrong first value stays unarmed", armed, 1'b0);
        bus_write(OFS0, K0, 4'hF);
        bus_write(OFS0, K0 ^ 32'h1, 4'hF);
        check("R5 wrong first value disarms", armed, 1'b0);
    endtask

    task automatic t_partial();
        bus_write(OFS0, K0, 4'h7);
        check("R6 partial first key not accepted", armed, 1'b0);
        bus_write(OFS0, K0, 4'hF);
        bus_write(OFS1, K1, 4'hE);
        check("R6 partial second key seals", locked, 1'b1);
        check("R6 partial second key disarms", armed, 1'b0);
    endtask

    task automatic t_rearm();
        open_gate();
        check("R3 open before re-arm", locked, 1'b0);
        bus_write(OFS0, K0, 4'hF);
        check("R9 first key while open locks", locked, 1'b1);
        check("R9 first key while open arms", armed, 1'b1);
        bus_write(8'h08, 32'h1, 4'hF);
        check("R9 write blocked while re-armed", seen_wr, 1'b0);
        bus_write(OFS1, K1, 4'hF);
        check("R9 second key reopens", locked, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_sealed_writes();
        t_unlock();
        t_zero_relock();
        t_order();
        t_bad_values();
        t_partial();
        t_rearm();
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule